// File: doc/BRIEF.md
# Interrupt Acknowledge Vectoring Sequencer

This block is the processor-side sequencer that serves a maskable interrupt request. At an instruction boundary the core asks whether to start an opcode fetch. If the request line is high and the interrupt-enable flag is set, the block runs an acknowledge sequence instead of the fetch. It then disables further maskable interrupts.

The sequence has three acknowledge read cycles, strobed by the acknowledge output, with the I/O-space indicator high. The external interrupt controller drives a subroutine-call opcode in the first cycle and a 16-bit target address over the other two. The program counter is held unchanged during all three cycles. The block then pre-decrements the stack pointer and pushes the return address, high byte first, through a memory-write request port. Last, it loads the collected target into the program counter.

If the first byte is not the call opcode, the sequence is abandoned with an error pulse and no change to either pointer. The interrupt-enable flag is set only by an explicit enable command.

Top module: `intack_seq`

## Requirements
- R1: After a synchronous reset, ie_o, busy_o, inta_o, io_m_o, wr_req_o and err_o are 0, and pc_o and sp_o are 0x0000.
- R2: ei_i sets ie_o on the next clock and di_i clears it. When both are high in the same cycle, di_i wins.
- R3: A request is accepted only on a clock where boundary_i, intr_i and ie_o are all 1 and the block is idle. intr_i without boundary_i, or with ie_o at 0, starts nothing.
- R4: On acceptance, ie_o is 0 from the next clock. The sequence itself never sets it again.
- R5: After acceptance, inta_o and io_m_o stay high for 10 consecutive clocks: 4 for the opcode cycle, then 3 for each address byte. data_i is sampled on the last clock of each cycle. pc_o does not change while inta_o is high.
- R6: If the opcode byte is not 0xCD, err_o pulses high for exactly one clock as the block returns to idle. No write is issued, and pc_o and sp_o are unchanged.
- R7: The stack pointer is decremented before each push byte. The first write goes to address SP0-1 with the high PC byte, and the second goes to SP0-2 with the low PC byte. wr_req_o and the write address hold until wr_done_i is seen.
- R8: After the second write completes, pc_o equals {third byte, second byte} and sp_o equals SP0-2. All address arithmetic wraps modulo 2^16.
- R9: pc_ld_i and sp_ld_i are ignored while busy_o is high.
- R10: busy_o is high from the clock after acceptance until the sequence ends, whether the call completes or is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intr_i | input | 1 | Maskable interrupt request |
| boundary_i | input | 1 | High in the clock state just before the first cycle of an instruction |
| ei_i | input | 1 | Enable-interrupt command |
| di_i | input | 1 | Disable-interrupt command |
| data_i | input | 8 | Byte returned by the interrupt controller |
| pc_ld_i | input | 1 | External program counter load |
| pc_din_i | input | 16 | Program counter load value |
| sp_ld_i | input | 1 | External stack pointer load |
| sp_din_i | input | 16 | Stack pointer load value |
| wr_done_i | input | 1 | Memory write completed |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| io_m_o | output | 1 | I/O-space indicator, high during acknowledge cycles |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | 16 | Memory write address (the current stack pointer) |
| wr_data_o | output | 8 | Memory write byte |
| pc_o | output | 16 | Program counter; this is also the address presented during acknowledge |
| sp_o | output | 16 | Stack pointer |
| ie_o | output | 1 | Interrupt-enable flag |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | One-clock pulse when a wrong opcode byte is received |

## Verification
The properties assume that the memory side raises wr_done_i only while wr_req_o is high, for one clock per write. The bench's responder follows this rule: it answers each request with a single-clock done and waits for that done to drop before it looks at the next request.

The properties also assume that no pointer load is attempted on the same clock as acceptance. The bench issues loads only well before a request, or in the middle of an acknowledge cycle. data_i is held steady for the whole of each acknowledge cycle, so the exact sampling clock inside a cycle does not change the collected byte.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_OP,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_PUSH_HI,
    ST_PUSH_LO
  } seq_state_t;
endpackage

// File: rtl/intack_ie_ff.sv
module intack_ie_ff (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic ei_i,
  input  logic di_i,
  output logic ie_o
);
  // Acceptance clears first, then disable, then enable.
  always_ff @(posedge clk) begin
    if (rst)         ie_o <= 1'b0;
    else if (take_i) ie_o <= 1'b0;
    else if (di_i)   ie_o <= 1'b0;
    else if (ei_i)   ie_o <= 1'b1;
  end
endmodule

// File: rtl/intack_tcount.sv
module intack_tcount #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (run_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/intack_ptr_regs.sv
module intack_ptr_regs #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic          pc_ld_i,
  input  logic [AW-1:0] pc_din_i,
  input  logic          sp_ld_i,
  input  logic [AW-1:0] sp_din_i,
  input  logic          sp_dec_i,
  input  logic          pc_jump_i,
  input  logic [AW-1:0] jump_addr_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o <= '0;
      sp_o <= '0;
    end else begin
      if (pc_jump_i)              pc_o <= jump_addr_i;
      else if (pc_ld_i && !busy_i) pc_o <= pc_din_i;
      if (sp_dec_i)               sp_o <= sp_o - 1'b1;
      else if (sp_ld_i && !busy_i) sp_o <= sp_din_i;
    end
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq
  import intack_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            ACK_OP_T   = 4,
  parameter int            ACK_BYTE_T = 3,
  parameter logic [DW-1:0] CALL_OP    = 8'hCD
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            intr_i,
  input  logic            boundary_i,
  input  logic            ei_i,
  input  logic            di_i,
  input  logic [DW-1:0]   data_i,
  input  logic            pc_ld_i,
  input  logic [2*DW-1:0] pc_din_i,
  input  logic            sp_ld_i,
  input  logic [2*DW-1:0] sp_din_i,
  input  logic            wr_done_i,
  output logic            inta_o,
  output logic            io_m_o,
  output logic            wr_req_o,
  output logic [2*DW-1:0] wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic [2*DW-1:0] pc_o,
  output logic [2*DW-1:0] sp_o,
  output logic            ie_o,
  output logic            busy_o,
  output logic            err_o
);
  localparam int AW   = 2 * DW;
  localparam int TMAX = (ACK_OP_T > ACK_BYTE_T) ? ACK_OP_T : ACK_BYTE_T;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LAST_OP   = CW'(ACK_OP_T - 1);
  localparam logic [CW-1:0] LAST_BYTE = CW'(ACK_BYTE_T - 1);

  seq_state_t     state_q, state_d;
  logic           take, in_ack, last, bad;
  logic           sp_dec, pc_jump;
  logic [CW-1:0]  tcnt;
  logic [DW-1:0]  lo_q, hi_q;

  assign take   = (state_q == ST_IDLE) && boundary_i && intr_i && ie_o;
  assign in_ack = (state_q == ST_ACK_OP) || (state_q == ST_ACK_LO) ||
                  (state_q == ST_ACK_HI);
  assign last   = in_ack &&
                  (tcnt == ((state_q == ST_ACK_OP) ? LAST_OP : LAST_BYTE));
  assign bad    = (state_q == ST_ACK_OP) && last && (data_i != CALL_OP);
  assign sp_dec = ((state_q == ST_ACK_HI) && last) ||
                  ((state_q == ST_PUSH_HI) && wr_done_i);
  assign pc_jump = (state_q == ST_PUSH_LO) && wr_done_i;

  intack_ie_ff u_ie (
    .clk    (clk),
    .rst    (rst),
    .take_i (take),
    .ei_i   (ei_i),
    .di_i   (di_i),
    .ie_o   (ie_o)
  );

  intack_tcount #(.CW(CW)) u_tcnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (take || last),
    .run_i (in_ack),
    .cnt_o (tcnt)
  );

  intack_ptr_regs #(.AW(AW)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy_o),
    .pc_ld_i     (pc_ld_i),
    .pc_din_i    (pc_din_i),
    .sp_ld_i     (sp_ld_i),
    .sp_din_i    (sp_din_i),
    .sp_dec_i    (sp_dec),
    .pc_jump_i   (pc_jump),
    .jump_addr_i ({hi_q, lo_q}),
    .pc_o        (pc_o),
    .sp_o        (sp_o)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (take) state_d = ST_ACK_OP;
      ST_ACK_OP:  if (last) state_d = bad ? ST_IDLE : ST_ACK_LO;
      ST_ACK_LO:  if (last) state_d = ST_ACK_HI;
      ST_ACK_HI:  if (last) state_d = ST_PUSH_HI;
      ST_PUSH_HI: if (wr_done_i) state_d = ST_PUSH_LO;
      ST_PUSH_LO: if (wr_done_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // State, collected bytes and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      lo_q      <= '0;
      hi_q      <= '0;
      inta_o    <= 1'b0;
      io_m_o    <= 1'b0;
      wr_req_o  <= 1'b0;
      wr_data_o <= '0;
      busy_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_ACK_LO) && last) lo_q <= data_i;
      if ((state_q == ST_ACK_HI) && last) hi_q <= data_i;
      inta_o   <= (state_d == ST_ACK_OP) || (state_d == ST_ACK_LO) ||
                  (state_d == ST_ACK_HI);
      io_m_o   <= (state_d == ST_ACK_OP) || (state_d == ST_ACK_LO) ||
                  (state_d == ST_ACK_HI);
      wr_req_o <= (state_d == ST_PUSH_HI) || (state_d == ST_PUSH_LO);
      wr_data_o <= (state_d == ST_PUSH_HI) ? pc_o[AW-1:DW] : pc_o[DW-1:0];
      busy_o   <= (state_d != ST_IDLE);
      err_o    <= bad;
    end
  end

  assign wr_addr_o = sp_o;
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ie_o,
  input logic          busy_o,
  input logic          inta_o,
  input logic          wr_req_o,
  input logic          wr_done_i,
  input logic          err_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] sp_o
);
  // R4: acceptance leaves the enable flag clear
  a_r4_ie_cleared: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !ie_o);

  // R5: program counter frozen across acknowledge cycles
  a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (inta_o && $past(inta_o)) |-> $stable(pc_o));

  // R10: acknowledge only while the sequence is busy
  a_r10_inta_busy: assert property (@(posedge clk) disable iff (rst)
    inta_o |-> busy_o);

  // R7: pre-decrement on entry to the first push
  a_r7_sp_predec: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_req_o) |-> (sp_o == $past(sp_o) - 1'b1));

  // R7: request and address held until completion
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req_o && !wr_done_i) |=> (wr_req_o && $stable(sp_o)));

  // R6: error is a single pulse with the pointers untouched
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  a_r6_err_idle: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && $stable(sp_o) && $stable(pc_o)));
endmodule

bind intack_seq intack_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ie_o      (ie_o),
  .busy_o    (busy_o),
  .inta_o    (inta_o),
  .wr_req_o  (wr_req_o),
  .wr_done_i (wr_done_i),
  .err_o     (err_o),
  .pc_o      (pc_o),
  .sp_o      (sp_o)
);

// File: tb/tb_intack_seq.sv
module tb_intack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [15:0] pc0;
    logic [15:0] sp0;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [7:0]  b3;
    logic        ie;
    logic        intr;
    logic        taken;
    logic        err;
    logic [15:0] exp_pc;
    logic [15:0] exp_sp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 16'h8000, 8'hCD, 8'h00, 8'h38, 1'b1, 1'b1, 1'b1, 1'b0, 16'h3800, 16'h7FFE},
    '{16'hABCD, 16'h0001, 8'hCD, 8'h55, 8'hAA, 1'b1, 1'b1, 1'b1, 1'b0, 16'hAA55, 16'hFFFF},
    '{16'h0100, 16'h4000, 8'hC3, 8'h11, 8'h22, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0100, 16'h4000},
    '{16'h0200, 16'h4000, 8'hCD, 8'h11, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h4000},
    '{16'h0300, 16'h2000, 8'hCD, 8'h11, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0300, 16'h2000},
    '{16'hFFFF, 16'h0000, 8'hCD, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'hFFFE}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic intr_i = 0, boundary_i = 0, ei_i = 0, di_i = 0;
  logic [7:0] data_i = '0;
  logic pc_ld_i = 0, sp_ld_i = 0, wr_done_i = 0;
  logic [15:0] pc_din_i = '0, sp_din_i = '0;
  logic inta_o, io_m_o, wr_req_o, ie_o, busy_o, err_o;
  logic [15:0] wr_addr_o, pc_o, sp_o;
  logic [7:0] wr_data_o;

  int nchk = 0, nerr = 0, cyc = 0;
  int n_inta, n_wr;
  logic saw_err;
  logic [15:0] wa [2];
  logic [7:0]  wd [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  intack_seq dut (
    .clk(clk), .rst(rst), .intr_i(intr_i), .boundary_i(boundary_i),
    .ei_i(ei_i), .di_i(di_i), .data_i(data_i), .pc_ld_i(pc_ld_i),
    .pc_din_i(pc_din_i), .sp_ld_i(sp_ld_i), .sp_din_i(sp_din_i),
    .wr_done_i(wr_done_i), .inta_o(inta_o), .io_m_o(io_m_o),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .pc_o(pc_o), .sp_o(sp_o), .ie_o(ie_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  // Load pointers and set the enable flag, then raise one request.
  task automatic run_seq(input vec_t v, input logic load_mid);
    logic seen_busy = 1'b0;
    logic io_ok = 1'b1, pc_ok = 1'b1, ie_ok = 1'b1;
    n_inta = 0; n_wr = 0; saw_err = 1'b0;
    @(negedge clk);
    pc_ld_i = 1; pc_din_i = v.pc0; sp_ld_i = 1; sp_din_i = v.sp0;
    ei_i = v.ie; di_i = !v.ie;
    @(negedge clk);
    pc_ld_i = 0; sp_ld_i = 0; ei_i = 0; di_i = 0;
    intr_i = v.intr; boundary_i = 1;
    @(negedge clk);
    intr_i = 0; boundary_i = 0;
    for (int k = 0; k < 60; k++) begin
      if (busy_o && !seen_busy) begin
        seen_busy = 1'b1;
        if (ie_o) ie_ok = 1'b0;
      end
      pc_ld_i = 0; sp_ld_i = 0;
      if (inta_o) begin
        if (!io_m_o) io_ok = 1'b0;
        if (pc_o != v.pc0) pc_ok = 1'b0;
        data_i = (n_inta < 4) ? v.b1 : (n_inta < 7) ? v.b2 : v.b3;
        if (load_mid && n_inta == 2) begin
          pc_ld_i = 1; pc_din_i = 16'h5555; sp_ld_i = 1; sp_din_i = 16'h6666;
        end
        n_inta++;
      end
      if (wr_req_o && !wr_done_i) begin
        if (n_wr < 2) begin wa[n_wr] = wr_addr_o; wd[n_wr] = wr_data_o; end
        n_wr++;
        wr_done_i = 1;
      end else wr_done_i = 0;
      if (err_o) saw_err = 1'b1;
      if (seen_busy && !busy_o) break;
      if (!seen_busy && k > 15) break;
      @(negedge clk);
    end
    wr_done_i = 0; pc_ld_i = 0; sp_ld_i = 0;
    check(seen_busy == v.taken, "R3 R10 acceptance", seen_busy, v.taken);
    check(ie_ok, "R4 ie clear after accept", ie_ok, 1);
    check(io_ok && pc_ok, "R5 io_m high and pc held", {io_ok, pc_ok}, 2'b11);
    check(n_inta == (!v.taken ? 0 : v.err ? 4 : 10), "R5 ack clock count",
          n_inta, (!v.taken ? 0 : v.err ? 4 : 10));
    check(saw_err == v.err, "R6 err pulse", saw_err, v.err);
    check(pc_o == v.exp_pc, "R8 final pc", pc_o, v.exp_pc);
    check(sp_o == v.exp_sp, "R8 final sp", sp_o, v.exp_sp);
    if (v.taken && !v.err) begin
      check(n_wr == 2, "R7 write count", n_wr, 2);
      check(wa[0] == v.sp0 - 16'd1 && wd[0] == v.pc0[15:8], "R7 first push",
            {wa[0], wd[0]}, {v.sp0 - 16'd1, v.pc0[15:8]});
      check(wa[1] == v.sp0 - 16'd2 && wd[1] == v.pc0[7:0], "R7 second push",
            {wa[1], wd[1]}, {v.sp0 - 16'd2, v.pc0[7:0]});
    end else
      check(n_wr == 0, "R6 no write", n_wr, 0);
    if (v.taken)
      check(ie_o == 1'b0, "R4 ie stays clear", ie_o, 0);
    else
      check(ie_o == v.ie, "R2 ie unchanged", ie_o, v.ie);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!ie_o && !busy_o && !inta_o && !io_m_o && !wr_req_o && !err_o,
          "R1 reset flags", {ie_o, busy_o, inta_o, io_m_o, wr_req_o, err_o}, 0);
    check(pc_o == 0 && sp_o == 0, "R1 reset pointers", {pc_o, sp_o}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) run_seq(VECS[i], 1'b0);

    // R2 enable and disable priority
    ei_i = 1; @(negedge clk); ei_i = 0;
    check(ie_o == 1, "R2 ei sets", ie_o, 1);
    ei_i = 1; di_i = 1; @(negedge clk); ei_i = 0; di_i = 0;
    check(ie_o == 0, "R2 di wins", ie_o, 0);

    // R3 request without boundary is ignored
    ei_i = 1; @(negedge clk); ei_i = 0;
    intr_i = 1;
    repeat (6) @(negedge clk);
    check(!busy_o && !inta_o, "R3 no boundary", {busy_o, inta_o}, 0);
    check(ie_o == 1, "R3 ie kept", ie_o, 1);
    intr_i = 0;

    // R9 pointer loads during the sequence are ignored
    run_seq('{16'h4321, 16'h9000, 8'hCD, 8'h34, 8'h12, 1'b1, 1'b1, 1'b1, 1'b0,
              16'h1234, 16'h8FFE}, 1'b1);
    check(pc_o == 16'h1234, "R9 load ignored", pc_o, 16'h1234);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule